// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Page Permissions

This block keeps recently used virtual-to-physical page translations for 4 KB pages so that most memory accesses skip the page-table walk. A lookup presents a 20-bit virtual page number, the 12-bit page offset, whether the access writes, and whether it comes from user mode. One cycle later the block answers with exactly one outcome: a hit carrying the full physical address, a protection fault, or a miss.

A miss tells an external walker to fetch the mapping. The walker then installs the result through a separate refill port. Each entry carries four attribute flags: global, supervisor-only, writable and dirty. These flags drive the permission checks and decide which entries survive a context flush. A write to a writable page whose dirty flag is still clear is answered as a miss. The walker can then mark the page dirty in memory and refill the entry with the flag set. Two maintenance commands are provided. A context flush drops every entry that is not global. A single-page invalidate removes one translation whatever its flags are.

Top module: `tlb_core`

## Requirements
- R1: After reset every entry is invalid, all response outputs are 0, and any lookup misses.
- R2: A lookup accepted with `lk_valid` is answered on the next cycle with `rsp_valid` high and exactly one of `rsp_hit`, `rsp_fault`, `rsp_miss` high. With no lookup, all four are low. `rsp_paddr` is 0 unless `rsp_hit` is high.
- R3: The set index is VPN bits [3:0] and the tag is VPN bits [19:4]. A hit requires a valid entry with an equal tag in that set, and then `rsp_paddr` = {stored PPN, `lk_off`}. A different tag in the same set misses.
- R4: A lookup with `lk_user`=1 that hits a supervisor-only entry is a fault. The same entry hits for `lk_user`=0.
- R5: A lookup with `lk_write`=1 that hits a non-writable entry is a fault, even when the entry is clean. A read of that entry hits.
- R6: A write that hits a writable entry with a clear dirty flag is a miss. Reads of that entry hit, and writes to a dirty writable entry hit.
- R7: A refill whose VPN is already present overwrites that entry in place, so its new PPN and flags take effect and the other entries of the set are kept.
- R8: A refill into a set without a matching entry takes the lowest-numbered invalid way. When every way is valid, it takes the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one only after such an eviction.
- R9: `flush_all` invalidates every entry whose global flag is clear and keeps global entries.
- R10: `inv_valid` with `inv_vpn` invalidates the entry matching that VPN, even a global one, and leaves the other entries untouched.
- R11: A refill that arrives in the same cycle as `flush_all` is installed and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_off | input | 12 | Lookup page offset |
| lk_write | input | 1 | 1 = write access |
| lk_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Protection fault |
| rsp_miss | output | 1 | Walk needed |
| rsp_paddr | output | 32 | Physical address on hit |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page number |
| fill_global | input | 1 | Entry survives context flush |
| fill_super | input | 1 | Entry is supervisor-only |
| fill_writable | input | 1 | Entry may be written |
| fill_dirty | input | 1 | Page already dirty |
| flush_all | input | 1 | Drop all non-global entries |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | VPN to invalidate |

## Verification
The assertions check the response protocol on every cycle. They confirm that one outcome follows each lookup by one cycle, that nothing appears when no lookup was made, that the address is zero off a hit, and that a hit's low bits are the offset that was looked up. The bench scenarios show the rest, because those behaviours depend on the stored contents: the permission results, the forced miss on a write to a clean page, in-place refill, the victim choice and round-robin order, flush survival of global entries, single-page invalidate, and a refill that coincides with a flush.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef struct packed {
    logic glob;
    logic sup;
    logic wr;
    logic dirty;
  } tlb_flags_t;

  typedef enum logic [1:0] {
    TLB_MISS  = 2'd0,
    TLB_HIT   = 2'd1,
    TLB_FAULT = 2'd2
  } tlb_result_e;
endpackage

// File: rtl/tlb_way_match.sv
`timescale 1ns/1ps
module tlb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valid,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            match
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == tag);
  end
endmodule

// File: rtl/tlb_victim_pick.sv
`timescale 1ns/1ps
module tlb_victim_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  match,
  input  logic [WAY_W-1:0] ptr,
  output logic [WAY_W-1:0] way,
  output logic             use_ptr
);
  // priority: existing match, then lowest invalid way, then pointer
  always_comb begin
    way     = ptr;
    use_ptr = 1'b1;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        way     = WAY_W'(i);
        use_ptr = 1'b0;
      end
    end
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) begin
        way     = WAY_W'(i);
        use_ptr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_perm_check.sv
`timescale 1ns/1ps
module tlb_perm_check
  import tlb_pkg::*;
(
  input  logic        hit,
  input  tlb_flags_t  fl,
  input  logic        user,
  input  logic        write,
  output tlb_result_e res
);
  always_comb begin
    if (!hit)                        res = TLB_MISS;
    else if (user && fl.sup)         res = TLB_FAULT;
    else if (write && !fl.wr)        res = TLB_FAULT;
    else if (write && !fl.dirty)     res = TLB_MISS;  // walker must mark dirty
    else                             res = TLB_HIT;
  end
endmodule

// File: rtl/tlb_core.sv
`timescale 1ns/1ps
module tlb_core
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12,
  parameter int SETS  = 16,
  parameter int WAYS  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic                   lk_write,
  input  logic                   lk_user,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic                   rsp_miss,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_global,
  input  logic                   fill_super,
  input  logic                   fill_writable,
  input  logic                   fill_dirty,
  input  logic                   flush_all,
  input  logic                   inv_valid,
  input  logic [VPN_W-1:0]       inv_vpn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // storage: valid bits and pointers reset, payload written only on refill
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [WAY_W-1:0] ptr_q   [SETS];
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [PPN_W-1:0] ppn_mem [SETS][WAYS];
  tlb_flags_t       flg_mem [SETS][WAYS];

  // address split
  logic [IDX_W-1:0] lk_idx, fl_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag, inv_tag;
  assign lk_idx  = lk_vpn[IDX_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
  assign fl_idx  = fill_vpn[IDX_W-1:0];
  assign fl_tag  = fill_vpn[VPN_W-1:IDX_W];
  assign inv_idx = inv_vpn[IDX_W-1:0];
  assign inv_tag = inv_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0][TAG_W-1:0] lk_tags, fl_tags, inv_tags;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tags[w]  = tag_mem[lk_idx][w];
      fl_tags[w]  = tag_mem[fl_idx][w];
      inv_tags[w] = tag_mem[inv_idx][w];
    end
  end

  logic [WAYS-1:0] lk_match, fl_match, inv_match;

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .tags(lk_tags), .valid(valid_q[lk_idx]), .tag(lk_tag), .match(lk_match));
  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .tags(fl_tags), .valid(valid_q[fl_idx]), .tag(fl_tag), .match(fl_match));
  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_inv_match (
    .tags(inv_tags), .valid(valid_q[inv_idx]), .tag(inv_tag), .match(inv_match));

  // hit way payload
  tlb_flags_t       hit_fl;
  logic [PPN_W-1:0] hit_ppn;
  always_comb begin
    hit_fl  = '0;
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        hit_fl  = flg_mem[lk_idx][w];
        hit_ppn = ppn_mem[lk_idx][w];
      end
    end
  end

  tlb_result_e lk_res;
  tlb_perm_check u_perm (
    .hit(|lk_match), .fl(hit_fl), .user(lk_user), .write(lk_write), .res(lk_res));

  // refill victim
  logic [WAY_W-1:0] fl_way;
  logic             fl_use_ptr;
  tlb_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid(valid_q[fl_idx]), .match(fl_match), .ptr(ptr_q[fl_idx]),
    .way(fl_way), .use_ptr(fl_use_ptr));

  // next valid state: flush, then invalidate, then refill wins
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      valid_d[s] = valid_q[s];
      if (flush_all) begin
        for (int w = 0; w < WAYS; w++) begin
          if (!flg_mem[s][w].glob) valid_d[s][w] = 1'b0;
        end
      end
    end
    if (inv_valid) valid_d[inv_idx] = valid_d[inv_idx] & ~inv_match;
    if (fill_valid) valid_d[fl_idx][fl_way] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
      if (fill_valid && fl_use_ptr) ptr_q[fl_idx] <= ptr_q[fl_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_mem[fl_idx][fl_way] <= fl_tag;
      ppn_mem[fl_idx][fl_way] <= fill_ppn;
      flg_mem[fl_idx][fl_way] <= '{glob: fill_global, sup: fill_super,
                                   wr: fill_writable, dirty: fill_dirty};
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (lk_res == TLB_HIT);
      rsp_fault <= lk_valid && (lk_res == TLB_FAULT);
      rsp_miss  <= lk_valid && (lk_res == TLB_MISS);
      rsp_paddr <= (lk_valid && lk_res == TLB_HIT) ? {hit_ppn, lk_off} : '0;
    end
  end
endmodule

// File: rtl/tlb_core_chk.sv
`timescale 1ns/1ps
module tlb_core_chk #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [OFF_W-1:0] lk_off,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic             rsp_miss,
  input logic [PA_W-1:0]  rsp_paddr
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_miss}) == 1); // R2

  AST_NO_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit && !rsp_fault && !rsp_miss); // R2

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid); // R2

  AST_PA_ZERO_ELSE: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> rsp_paddr == '0); // R2

  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_off)); // R3
endmodule

bind tlb_core tlb_core_chk #(.OFF_W(OFF_W), .PA_W(PPN_W + OFF_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_off(lk_off),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr));

// File: tb/tlb_core_bench.sv
`timescale 1ns/1ps
module tlb_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_off = '0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 0, fill_global = 0, fill_super = 0, fill_writable = 0, fill_dirty = 0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        flush_all = 0, inv_valid = 0;
  logic [19:0] inv_vpn = '0;

  localparam int K_MISS = 0, K_HIT = 1, K_FAULT = 2;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_core u_tlb_core (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_write(lk_write), .lk_user(lk_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_global(fill_global), .fill_super(fill_super), .fill_writable(fill_writable),
    .fill_dirty(fill_dirty), .flush_all(flush_all), .inv_valid(inv_valid), .inv_vpn(inv_vpn));

  typedef struct {
    int          kind;
    logic [31:0] pa;
    string       rid;
  } exp_t;
  exp_t sb[$];

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      int got;
      got = (rsp_hit && !rsp_fault && !rsp_miss) ? K_HIT :
            (rsp_fault && !rsp_hit && !rsp_miss) ? K_FAULT :
            (rsp_miss && !rsp_hit && !rsp_fault) ? K_MISS : 9;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R2: unexpected response kind=%0d pa=%h expected none", got, rsp_paddr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (got != e.kind || rsp_paddr != e.pa) begin
          bad++;
          $display("FAIL %s: kind=%0d pa=%h expected kind=%0d pa=%h",
                   e.rid, got, rsp_paddr, e.kind, e.pa);
        end
      end
    end
  end

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off, input logic wr,
                        input logic usr, input int kind, input logic [19:0] ppn, input string rid);
    exp_t e;
    e.kind = kind;
    e.pa   = (kind == K_HIT) ? {ppn, off} : 32'h0;
    e.rid  = rid;
    sb.push_back(e);
    lk_valid = 1; lk_vpn = vpn; lk_off = off; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0; lk_user = 0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic g, input logic s, input logic w, input logic d,
                      input logic with_flush);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
    fill_global = g; fill_super = s; fill_writable = w; fill_dirty = d;
    flush_all = with_flush;
    @(negedge clk);
    fill_valid = 0; flush_all = 0;
  endtask

  task automatic flush();
    flush_all = 1;
    @(negedge clk);
    flush_all = 0;
  endtask

  task automatic inval(input logic [19:0] vpn);
    inv_valid = 1; inv_vpn = vpn;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: outputs clear after reset
    total++;
    if ({rsp_valid, rsp_hit, rsp_fault, rsp_miss} != 4'b0 || rsp_paddr != 0) begin
      bad++;
      $display("FAIL R1: outputs=%b pa=%h expected 0000 pa=0",
               {rsp_valid, rsp_hit, rsp_fault, rsp_miss}, rsp_paddr);
    end
    lookup(20'h00013, 12'h001, 0, 0, K_MISS, 0, "R1");

    // R3: basic hit, offset join, tag mismatch
    fill(20'h12343, 20'hABCDE, 0, 0, 1, 1, 0);
    lookup(20'h12343, 12'h5A5, 0, 1, K_HIT, 20'hABCDE, "R3");
    lookup(20'h12343, 12'hFFF, 1, 1, K_HIT, 20'hABCDE, "R6");
    lookup(20'h12353, 12'h000, 0, 0, K_MISS, 0, "R3");

    // R4: supervisor-only
    fill(20'h00A17, 20'h11111, 0, 1, 1, 1, 0);
    lookup(20'h00A17, 12'h010, 0, 1, K_FAULT, 0, "R4");
    lookup(20'h00A17, 12'h010, 0, 0, K_HIT, 20'h11111, "R4");

    // R5: read-only, clean -> fault wins over dirty miss
    fill(20'h00B27, 20'h22222, 0, 0, 0, 0, 0);
    lookup(20'h00B27, 12'h020, 1, 0, K_FAULT, 0, "R5");
    lookup(20'h00B27, 12'h020, 0, 1, K_HIT, 20'h22222, "R5");

    // R6: writable clean page forces walk on write
    fill(20'h00C37, 20'h33333, 0, 0, 1, 0, 0);
    lookup(20'h00C37, 12'h030, 1, 0, K_MISS, 0, "R6");
    lookup(20'h00C37, 12'h030, 0, 0, K_HIT, 20'h33333, "R6");

    // R7: refill in place
    fill(20'h00C37, 20'h33334, 0, 0, 1, 1, 0);
    lookup(20'h00C37, 12'h031, 1, 0, K_HIT, 20'h33334, "R7");
    lookup(20'h00A17, 12'h032, 0, 0, K_HIT, 20'h11111, "R7");
    lookup(20'h00B27, 12'h033, 0, 0, K_HIT, 20'h22222, "R7");

    // R8: victim choice in set 5
    for (int i = 0; i < 4; i++)
      fill({16'(i + 1), 4'h5}, 20'h50000 + 20'(i), 0, 0, 1, 1, 0);
    for (int i = 0; i < 4; i++)
      lookup({16'(i + 1), 4'h5}, 12'h0, 0, 0, K_HIT, 20'h50000 + 20'(i), "R8");
    fill(20'h00055, 20'h50004, 0, 0, 1, 1, 0);     // evicts way 0
    lookup(20'h00015, 12'h0, 0, 0, K_MISS, 0, "R8");
    lookup(20'h00025, 12'h0, 0, 0, K_HIT, 20'h50001, "R8");
    lookup(20'h00055, 12'h0, 0, 0, K_HIT, 20'h50004, "R8");
    fill(20'h00065, 20'h50005, 0, 0, 1, 1, 0);     // evicts way 1
    lookup(20'h00025, 12'h0, 0, 0, K_MISS, 0, "R8");
    lookup(20'h00035, 12'h0, 0, 0, K_HIT, 20'h50002, "R8");
    inval(20'h00045);                               // frees way 3
    lookup(20'h00045, 12'h0, 0, 0, K_MISS, 0, "R10");
    fill(20'h00075, 20'h50006, 0, 0, 1, 1, 0);     // takes invalid way 3
    lookup(20'h00035, 12'h0, 0, 0, K_HIT, 20'h50002, "R8");
    lookup(20'h00055, 12'h0, 0, 0, K_HIT, 20'h50004, "R8");
    lookup(20'h00065, 12'h0, 0, 0, K_HIT, 20'h50005, "R8");
    lookup(20'h00075, 12'h0, 0, 0, K_HIT, 20'h50006, "R8");

    // R9: flush keeps global
    fill(20'h00F09, 20'h99999, 1, 0, 1, 1, 0);
    flush();
    lookup(20'h12343, 12'h0, 0, 0, K_MISS, 0, "R9");
    lookup(20'h00A17, 12'h0, 0, 0, K_MISS, 0, "R9");
    lookup(20'h00F09, 12'h444, 0, 1, K_HIT, 20'h99999, "R9");

    // R10: invalidate removes global entry, neighbour untouched
    fill(20'h00F19, 20'h88888, 0, 0, 1, 1, 0);
    inval(20'h00F09);
    lookup(20'h00F09, 12'h0, 0, 0, K_MISS, 0, "R10");
    lookup(20'h00F19, 12'h0, 0, 0, K_HIT, 20'h88888, "R10");

    // R11: refill alongside flush survives
    fill(20'h0AAA2, 20'h77777, 0, 0, 1, 1, 1);
    lookup(20'h0AAA2, 12'h123, 0, 0, K_HIT, 20'h77777, "R11");
    lookup(20'h00F19, 12'h0, 0, 0, K_MISS, 0, "R11");

    repeat (3) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2: %0d responses missing expected 0", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, got no end expected end");
      summary();
      $finish;
    end
  end
endmodule